// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block holds sixty-four general-purpose pins arranged as four banks of sixteen. Per pin it stores a direction, an output value and an alternate-function select, reports the synchronized pad level, and turns pin activity into interrupts. Each pin has three detection bits: a detect-mode bit (edge or level), an edge-polarity bit and a level-polarity bit. The pin's condition sets a sticky status bit. A per-pin mask bit decides whether that status bit takes part in the bank's request.

A top-level interrupt unit gathers the four bank requests and six other peripheral request lines into a 10-bit pending word. It gates that word with an enable register that also holds a global enable bit, and drives one registered upstream interrupt. Software reaches every register through a flat 16-bit read/write port. Writes take effect on the clock edge. Reads are combinational from the address.

Address map: bit 6 of the address selects the top-level unit. Otherwise bits 5:4 give the bank and bits 3:0 the bank register: 0 direction, 1 output, 2 alternate select, 3 pin level (read-only), 4 mask, 5 detect mode, 6 edge polarity, 7 level polarity, 8 sticky status. In the top-level unit, index 0 is the pending word (read-only) and index 1 is the enable register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the following registers read back as shown.
  - Direction, output, alternate select, detect mode, edge polarity and level polarity read 0.
  - Every bank mask reads 0xFFFF.
  - The top-level enable register reads 0.
  - irq_out is 0 and pin_oe is 0.
- R2: The pin outputs follow the bank registers as follows.
  - pin_oe equals the direction register, where 1 means output and 0 means input.
  - pin_out is the output register ANDed with direction, so it is 0 on input pins.
  - alt_sel equals the alternate-select register.
  - The output register reads back as written.
- R3: The pin-level register (index 3) returns the pad input after a two-flop synchronizer, whatever the pin's direction.
- R4: A pin with detect mode 1 and edge polarity 1 sets its status bit on a 0-to-1 transition of the synchronized level, and not on a 1-to-0 transition.
- R5: A pin with detect mode 1 and edge polarity 0 sets its status bit on a 1-to-0 transition, and not on a 0-to-1 transition.
- R6: A pin with detect mode 0 sets its status bit while its synchronized level equals the level-polarity bit (1 means active-high, 0 means active-low). The bit stays set after the level goes away.
- R7: A write to the status register replaces it with its old value ANDed with the written data, plus any condition arriving in that cycle. Writing zero clears every latched bit. Without a write, status bits never clear.
- R8: The mask register works as set-to-mask. A bank request is the OR of the status bits whose mask bit is 0. Status bits still latch while masked.
- R9: The top-level pending word is built as follows.
  - Bits 0 to 3 are the requests of banks 0 to 3.
  - Bits 4 to 9 are the six peripheral request lines, with line 0 at bit 4.
  - Bits 10 to 15 read 0.
- R10: The top-level enable register works as set-to-enable.
  - Bits 0 to 9 enable the matching pending bits. Bit 15 is the global enable. Other bits are not stored and read 0.
  - One clock after the condition, irq_out is 1 exactly when the global enable is 1 and some enabled pending bit is 1.
- R11: Unused register indices read 0. These are bank indices 9 to 15 and top-level indices 2 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| pin_in | input | 64 | Pad input levels, bank b on bits 16b+15:16b |
| pin_out | output | 64 | Pad output values |
| pin_oe | output | 64 | Pad output enables |
| alt_sel | output | 64 | Alternate-function selects |
| ext_req | input | 6 | Other peripheral request lines |
| irq_out | output | 1 | Upstream interrupt |

## Verification
The RTL assertions are checked on every cycle. They cover four things:
- latched status never drops without a status write;
- a status write clears the written-zero bits that had no fresh condition;
- selected rising and falling edges of the synchronized level reach the status register one clock later;
- a fully masked bank raises no request, and irq_out never rises without the global enable.

Some behaviour only the bench scenarios can show. That includes the exact readback values and the direction gating of the pad outputs. It also includes the fact that the opposite edge leaves status untouched, that level status stays after the level drops, the bit layout of the pending word, and the one-cycle delay of irq_out through the enable register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [3:0] {
    RG_DIR = 4'd0,
    RG_OUT = 4'd1,
    RG_ALT = 4'd2,
    RG_PIN = 4'd3,
    RG_MSK = 4'd4,
    RG_TRG = 4'd5,
    RG_EDG = 4'd6,
    RG_LVL = 4'd7,
    RG_IST = 4'd8
  } bank_reg_e;

  localparam logic [3:0] TOP_PEND = 4'd0;
  localparam logic [3:0] TOP_ENAB = 4'd1;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= raw;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 16,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            sel,
  input  logic [3:0]      reg_idx,
  input  logic [DW-1:0]   wdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] alt_sel,
  output logic [DW-1:0]   rd_data,
  output logic            req
);
  logic [PINS-1:0] dir_q, out_q, alt_q, msk_q, trg_q, edg_q, lvl_q, ist_q;
  logic [PINS-1:0] dir_d, out_d, alt_d, msk_d, trg_d, edg_d, lvl_d, ist_d;
  logic [PINS-1:0] cur, prv, hit, wv;
  logic            wr_dir, wr_out, wr_alt, wr_msk, wr_trg, wr_edg, wr_lvl, wr_ist;

  gpio_pin_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur), .prv(prv)
  );

  assign wv     = wdata[PINS-1:0];
  assign wr_dir = wr_en && sel && (reg_idx == RG_DIR);
  assign wr_out = wr_en && sel && (reg_idx == RG_OUT);
  assign wr_alt = wr_en && sel && (reg_idx == RG_ALT);
  assign wr_msk = wr_en && sel && (reg_idx == RG_MSK);
  assign wr_trg = wr_en && sel && (reg_idx == RG_TRG);
  assign wr_edg = wr_en && sel && (reg_idx == RG_EDG);
  assign wr_lvl = wr_en && sel && (reg_idx == RG_LVL);
  assign wr_ist = wr_en && sel && (reg_idx == RG_IST);

  // per-pin condition: edge mode compares current and previous levels
  assign hit = (trg_q & ((edg_q & cur & ~prv) | (~edg_q & ~cur & prv)))
             | (~trg_q & ((lvl_q & cur) | (~lvl_q & ~cur)));

  always_comb begin
    dir_d = wr_dir ? wv : dir_q;
    out_d = wr_out ? wv : out_q;
    alt_d = wr_alt ? wv : alt_q;
    msk_d = wr_msk ? wv : msk_q;
    trg_d = wr_trg ? wv : trg_q;
    edg_d = wr_edg ? wv : edg_q;
    lvl_d = wr_lvl ? wv : lvl_q;
    ist_d = (wr_ist ? (ist_q & wv) : ist_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      alt_q <= '0;
      msk_q <= '1;
      trg_q <= '0;
      edg_q <= '0;
      lvl_q <= '0;
      ist_q <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
      alt_q <= alt_d;
      msk_q <= msk_d;
      trg_q <= trg_d;
      edg_q <= edg_d;
      lvl_q <= lvl_d;
      ist_q <= ist_d;
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;
  assign alt_sel = alt_q;
  assign req     = |(ist_q & ~msk_q);

  always_comb begin
    rd_data = '0;
    case (reg_idx)
      RG_DIR:  rd_data[PINS-1:0] = dir_q;
      RG_OUT:  rd_data[PINS-1:0] = out_q;
      RG_ALT:  rd_data[PINS-1:0] = alt_q;
      RG_PIN:  rd_data[PINS-1:0] = cur;
      RG_MSK:  rd_data[PINS-1:0] = msk_q;
      RG_TRG:  rd_data[PINS-1:0] = trg_q;
      RG_EDG:  rd_data[PINS-1:0] = edg_q;
      RG_LVL:  rd_data[PINS-1:0] = lvl_q;
      RG_IST:  rd_data[PINS-1:0] = ist_q;
      default: rd_data = '0;
    endcase
  end

  // latched bits stay set unless software writes the status register
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ist |=> ((ist_q & $past(ist_q)) == $past(ist_q)));

  // a status write clears the written-zero bits that had no fresh condition
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ist |=> ((ist_q & ~$past(hit) & ~$past(wv)) == '0));

  assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ist_q & $past(cur & ~prv & trg_q & edg_q)) == $past(cur & ~prv & trg_q & edg_q)));

  assert_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ist_q & $past(~cur & prv & trg_q & ~edg_q)) == $past(~cur & prv & trg_q & ~edg_q)));

  assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_q) |-> !req);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NB   = 4,
  parameter int NX   = 6,
  parameter int DW   = 16,
  parameter int GBIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_enab,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] bank_req,
  input  logic [NX-1:0] ext_req,
  output logic [DW-1:0] pend,
  output logic [DW-1:0] enab,
  output logic          irq_out
);
  localparam int NSRC = NB + NX;
  localparam logic [DW-1:0] KEEP = (DW'(1) << GBIT) | ((DW'(1) << NSRC) - DW'(1));

  logic [DW-1:0] en_q, en_d;
  logic          irq_q, irq_d;

  always_comb begin
    pend = '0;
    pend[NB-1:0]    = bank_req;
    pend[NSRC-1:NB] = ext_req;
  end

  always_comb begin
    en_d  = wr_enab ? (wdata & KEEP) : en_q;
    irq_d = en_q[GBIT] && (|(pend[NSRC-1:0] & en_q[NSRC-1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign enab    = en_q;
  assign irq_out = irq_q;

  assert_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(en_q[GBIT]));

  assert_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(pend[NSRC-1:0] & en_q[NSRC-1:0]) != '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NB   = 4,
  parameter int PINS = 16,
  parameter int NX   = 6,
  parameter int DW   = 16,
  parameter int GBIT = 15,
  localparam int BW  = $clog2(NB),
  localparam int AW  = BW + 5,
  localparam int NP  = NB * PINS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NP-1:0] pin_in,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] alt_sel,
  input  logic [NX-1:0] ext_req,
  output logic          irq_out
);
  logic          is_top;
  logic [BW-1:0] bank_idx;
  logic [3:0]    reg_idx;
  logic [NB-1:0] bank_req;
  logic [DW-1:0] bank_rd [NB];
  logic [DW-1:0] pend, enab;

  assign is_top   = addr[AW-1];
  assign bank_idx = addr[AW-2 -: BW];
  assign reg_idx  = addr[3:0];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    gpio_bank #(.PINS(PINS), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .sel(!is_top && (bank_idx == BW'(b))),
      .reg_idx(reg_idx), .wdata(wdata),
      .pin_in(pin_in[b*PINS +: PINS]),
      .pin_out(pin_out[b*PINS +: PINS]),
      .pin_oe(pin_oe[b*PINS +: PINS]),
      .alt_sel(alt_sel[b*PINS +: PINS]),
      .rd_data(bank_rd[b]),
      .req(bank_req[b])
    );
  end

  gpio_irq_unit #(.NB(NB), .NX(NX), .DW(DW), .GBIT(GBIT)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_enab(wr_en && is_top && (reg_idx == TOP_ENAB)),
    .wdata(wdata), .bank_req(bank_req), .ext_req(ext_req),
    .pend(pend), .enab(enab), .irq_out(irq_out)
  );

  always_comb begin
    rdata = '0;
    if (is_top) begin
      case (reg_idx)
        TOP_PEND: rdata = pend;
        TOP_ENAB: rdata = enab;
        default:  rdata = '0;
      endcase
    end else begin
      rdata = bank_rd[bank_idx];
    end
  end
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe, alt_sel;
  logic [5:0]  ext_req = '0;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_sel(alt_sel), .ext_req(ext_req), .irq_out(irq_out)
  );

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = rdata;
        1: act = {15'd0, irq_out};
        2: act = pin_out[15:0];
        3: act = pin_oe[15:0];
        default: act = alt_sel[15:0];
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic expect_item(input int sel, input logic [6:0] a,
                             input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
    #1;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  function automatic logic [6:0] ba(input int b, input int r);
    return {1'b0, 2'(b), 4'(r)};
  endfunction

  localparam logic [6:0] A_PEND = 7'h40;
  localparam logic [6:0] A_ENAB = 7'h41;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    expect_item(0, ba(0,0), 16'h0000, "R1 dir");
    expect_item(0, ba(1,4), 16'hFFFF, "R1 mask");
    expect_item(0, ba(3,5), 16'h0000, "R1 trig");
    expect_item(0, ba(2,7), 16'h0000, "R1 level");
    expect_item(0, A_ENAB,  16'h0000, "R1 top enable");
    expect_item(1, A_PEND,  16'h0000, "R1 irq_out");
    expect_item(3, A_PEND,  16'h0000, "R1 pin_oe");

    // R2 direction gating and alternate select
    wr(ba(0,0), 16'h00FF);
    wr(ba(0,1), 16'h0F0F);
    wr(ba(0,2), 16'h1234);
    expect_item(2, A_PEND,  16'h000F, "R2 pin_out");
    expect_item(3, A_PEND,  16'h00FF, "R2 pin_oe");
    expect_item(4, A_PEND,  16'h1234, "R2 alt_sel");
    expect_item(0, ba(0,1), 16'h0F0F, "R2 out readback");

    // R3 synchronized pin level regardless of direction
    pin_in[15:0]  = 16'hA5A5;
    pin_in[63:48] = 16'h3C00;
    settle();
    expect_item(0, ba(0,3), 16'hA5A5, "R3 bank0 level");
    expect_item(0, ba(3,3), 16'h3C00, "R3 bank3 level");

    // configure bank 0: pins 0-7 edge, 8-15 level; pin0 rising, pin8 high
    pin_in[15:0] = 16'hFE00;
    wr(ba(0,5), 16'h00FF);
    wr(ba(0,6), 16'h0001);
    wr(ba(0,7), 16'h0100);
    settle();
    wr(ba(0,8), 16'h0000);
    expect_item(0, ba(0,8), 16'h0000, "R7 clear after config");

    // R4 rising edge
    pin_in[0] = 1'b1; settle();
    expect_item(0, ba(0,8), 16'h0001, "R4 rise latched");
    wr(ba(0,8), 16'h0000);
    pin_in[0] = 1'b0; settle();
    expect_item(0, ba(0,8), 16'h0000, "R4 fall ignored");

    // R5 falling edge
    pin_in[1] = 1'b1; settle();
    expect_item(0, ba(0,8), 16'h0000, "R5 rise ignored");
    pin_in[1] = 1'b0; settle();
    expect_item(0, ba(0,8), 16'h0002, "R5 fall latched");

    // R6 level, sticky after release
    pin_in[8] = 1'b1; settle();
    pin_in[8] = 1'b0; settle();
    expect_item(0, ba(0,8), 16'h0102, "R6 active-high sticky");
    pin_in[9] = 1'b0; settle();
    pin_in[9] = 1'b1; settle();
    expect_item(0, ba(0,8), 16'h0302, "R6 active-low sticky");

    // R7 AND-write semantics
    wr(ba(0,8), 16'hFDFF);
    expect_item(0, ba(0,8), 16'h0102, "R7 partial clear");
    wr(ba(0,8), 16'h0000);
    expect_item(0, ba(0,8), 16'h0000, "R7 zero clears");

    // R8 set-to-mask
    pin_in[0] = 1'b1; settle();
    expect_item(0, ba(0,8), 16'h0001, "R8 latches while masked");
    expect_item(0, A_PEND,  16'h0000, "R8 masked no request");
    wr(ba(0,4), 16'hFFFE);
    expect_item(0, A_PEND,  16'h0001, "R8 unmasked request");

    // R9 pending layout
    ext_req = 6'b100001;
    expect_item(0, A_PEND,  16'h0211, "R9 external bits");
    wr(ba(2,4), 16'h0000);
    expect_item(0, A_PEND,  16'h0215, "R9 bank2 bit");

    // R10 enable register and global gate
    wr(A_ENAB, 16'h0010);
    expect_item(1, A_PEND,  16'h0000, "R10 no global");
    wr(A_ENAB, 16'h8010);
    expect_item(1, A_PEND,  16'h0001, "R10 global on");
    ext_req = 6'b000000;
    expect_item(1, A_PEND,  16'h0000, "R10 source gone");
    wr(A_ENAB, 16'h8004);
    expect_item(1, A_PEND,  16'h0001, "R10 bank2 enabled");
    wr(A_ENAB, 16'h0004);
    expect_item(1, A_PEND,  16'h0000, "R10 global off");
    wr(A_ENAB, 16'hFFFF);
    expect_item(0, A_ENAB,  16'h83FF, "R10 stored bits");
    expect_item(1, A_PEND,  16'h0001, "R10 all enabled");

    // R11 unused indices
    expect_item(0, ba(0,9), 16'h0000, "R11 bank index 9");
    expect_item(0, 7'h42,   16'h0000, "R11 top index 2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule